// File: doc/BRIEF.md
# SPI Flash Configuration Stream Loader

After reset, this block reads a configuration image out of an external serial flash. It acts as the master on a four-wire serial link. It drives the active-low select, the serial clock and the command line. It keeps the pause control (`hold_n`) and the write-guard control (`wp_n`) inactive, and it samples the data line returned by the flash.

A start pulse latches the following values:
- a 24-bit start address,
- a byte count,
- a clock divisor,
- a 3-bit variant code, which picks the read opcode and the number of dummy bits.

The block then sends one header of 32 bits on `mosi`: the opcode, then the address. After the header it clocks data in without pause and hands each byte to a valid/ready consumer. A consumer that holds ready low stalls the serial clock.

The transfer ends when the byte count is reached or when `abort` is raised. The block then keeps select high for at least one serial clock period and pulses `done`. A byte count of zero gives an unbounded stream, which only `abort` ends. Variant codes with no defined configuration are refused, and `err` is raised.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk`, `busy`, `done`, `err` and `out_valid` are low. `hold_n` and `wp_n` are high at all times, including during a transfer.
- R2: The variant code sets the opcode and the dummy-bit count:
  - 3'b000 gives opcode 0x03 with 0 dummy bits.
  - 3'b001 gives opcode 0x0B with 8 dummy bits.
  - 3'b010 gives opcode 0x0B with 16 dummy bits.
- R3: A start while idle with a code from 3'b011 to 3'b111 leaves the block idle with `cs_n` high and sets `err`. `err` stays set until the next accepted start, which clears it.
- R4: After `cs_n` falls, `mosi` carries the opcode byte and then the 24-bit start address, each MSB first. `mosi` changes only when `sclk` falls or `cs_n` falls.
- R5: `sclk` is low whenever `cs_n` is high. Each `sclk` half period lasts `clk_div` system cycles, with 0 treated as 1. The first rise comes `clk_div` cycles after `cs_n` falls.
- R6: `miso` is sampled on `sclk` rising edges. After the header and the dummy bits, bits are assembled MSB first. Byte j equals the flash byte at address start+j, modulo 2^24.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds and `sclk` does not rise.
- R8: A nonzero byte count yields exactly that many bytes. A count of zero streams until `abort`.
- R9: `abort` during a transfer sets `cs_n` high, `sclk` low and `out_valid` low at the next clock. `done` still follows.
- R10: At the end of a transfer, `cs_n` stays high for at least 2*`clk_div` cycles, and the last byte is accepted, before `done` pulses for one cycle. `busy` is low from the `done` cycle on.
- R11: A start while busy is ignored. The running transfer keeps its address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, latches the setup inputs |
| variant | input | 3 | Opcode and dummy-bit selector |
| start_addr | input | 24 | First flash address |
| byte_count | input | CNT_W | Bytes to load, 0 = unbounded |
| clk_div | input | DIV_W | Serial clock half period in system cycles |
| abort | input | 1 | Ends the transfer early |
| cs_n | output | 1 | Flash select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Command and address to the flash |
| miso | input | 1 | Data from the flash |
| hold_n | output | 1 | Pause control, kept inactive (high) |
| wp_n | output | 1 | Write guard, kept inactive (high) |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| busy | output | 1 | Transfer or end gap in progress |
| done | output | 1 | One-cycle end pulse |
| err | output | 1 | Last start was refused for a reserved code |

## Verification
A wrong header shift register or a wrong rising-edge counter shows up first on `mosi`. The opcode or address that the flash model captures is then off within the first 32 serial clocks. A wrong dummy count or a wrong bit counter shifts every received byte by some bits, so it is seen at the very first handshake. Divider faults show up at the first `sclk` rise after `cs_n` falls, and byte-counter faults show up at the number of bytes delivered before `done`. A stall fault shows up as extra `sclk` rises while a byte waits unaccepted.

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       variant,
  input  logic [23:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             abort,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             hold_n,
  output logic             wp_n,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam logic [5:0] HDR_BITS = 6'd32;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} state_t;

  state_t           state;
  logic [DIV_W:0]   divcnt;
  logic [DIV_W-1:0] halfm1;
  logic [5:0]       pcnt, hdr_len;
  logic [31:0]      tx;
  logic [6:0]       rx;
  logic [2:0]       bitn;
  logic [CNT_W-1:0] nbytes, count_l;
  logic             last;

  logic [7:0] sel_op;
  logic [5:0] sel_dummy;
  logic       sel_ok;

  always_comb begin
    sel_op = 8'h0B;
    sel_dummy = 6'd0;
    sel_ok = 1'b1;
    case (variant)
      3'b000: begin sel_op = 8'h03; sel_dummy = 6'd0;  end
      3'b001: begin sel_op = 8'h0B; sel_dummy = 6'd8;  end
      3'b010: begin sel_op = 8'h0B; sel_dummy = 6'd16; end
      default: sel_ok = 1'b0;
    endcase
  end

  logic tick, gap_end, pending, rise, fall, in_data;
  assign tick    = divcnt == {1'b0, halfm1};
  assign gap_end = divcnt == {halfm1, 1'b1};
  assign pending = out_valid && !out_ready;
  assign rise    = (state == S_RUN) && tick && !sclk && !pending;
  assign fall    = (state == S_RUN) && tick && sclk;
  assign in_data = pcnt == hdr_len;

  assign cs_n   = state != S_RUN;
  assign busy   = state != S_IDLE;
  assign mosi   = (state == S_RUN) && tx[31];
  assign hold_n = 1'b1;
  assign wp_n   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      divcnt    <= '0;
      halfm1    <= '0;
      pcnt      <= '0;
      hdr_len   <= HDR_BITS;
      tx        <= '0;
      rx        <= '0;
      bitn      <= '0;
      nbytes    <= '0;
      count_l   <= '0;
      last      <= 1'b0;
      sclk      <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (sel_ok) begin
              state   <= S_RUN;
              err     <= 1'b0;
              tx      <= {sel_op, start_addr};
              hdr_len <= HDR_BITS + sel_dummy;
              halfm1  <= (clk_div == '0) ? '0 : clk_div - 1'b1;
              count_l <= byte_count;
              nbytes  <= '0;
              pcnt    <= '0;
              bitn    <= '0;
              last    <= 1'b0;
              divcnt  <= '0;
              sclk    <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_RUN: begin
          if (abort) begin
            state     <= S_GAP;
            sclk      <= 1'b0;
            divcnt    <= '0;
            out_valid <= 1'b0;
          end else begin
            if (!tick) divcnt <= divcnt + 1'b1;
            else if (rise || fall) divcnt <= '0;
            if (rise) begin
              sclk <= 1'b1;
              if (!in_data) begin
                pcnt <= pcnt + 6'd1;
              end else begin
                rx   <= {rx[5:0], miso};
                bitn <= bitn + 3'd1;
                if (bitn == 3'd7) begin
                  out_data  <= {rx, miso};
                  out_valid <= 1'b1;
                  nbytes    <= nbytes + 1'b1;
                  if (count_l != '0 && nbytes + 1'b1 == count_l) last <= 1'b1;
                end
              end
            end
            if (fall) begin
              sclk <= 1'b0;
              tx   <= {tx[30:0], 1'b0};
              if (last) begin
                state  <= S_GAP;
                divcnt <= '0;
              end
            end
          end
        end
        S_GAP: begin
          if (!gap_end) divcnt <= divcnt + 1'b1;
          else if (!out_valid) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_cfg_loader_props (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] variant,
  input logic       abort,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done,
  input logic       err
);
  a_r5_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r4_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$stable(mosi)) |-> ($fell(sclk) || $fell(cs_n)));

  a_r7_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

  a_r7_clock_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !sclk) |=> !sclk);

  a_r3_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && variant > 3'd2) |=> (!busy && err && cs_n));

  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && abort) |=> (cs_n && !sclk && !out_valid));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
endmodule

bind spi_cfg_loader spi_cfg_loader_props u_props (.*);

// File: tb/spi_cfg_loader_bench.sv
module spi_cfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, miso = 1'b0, out_ready = 1'b0;
  logic [2:0] variant = '0;
  logic [23:0] start_addr = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [DIV_W-1:0] clk_div = '0;
  logic cs_n, sclk, mosi, hold_n, wp_n, out_valid, busy, done, err;
  logic [7:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_loader #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_spi_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
    .start_addr(start_addr), .byte_count(byte_count), .clk_div(clk_div),
    .abort(abort), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .hold_n(hold_n), .wp_n(wp_n), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .done(done), .err(err));

  int checks = 0, errors = 0;
  int ready_pct = 100;
  int rx_n = 0;
  logic [7:0] rxbuf [0:511];

  logic [31:0] m_cmd = '0;
  int m_rise = 0;
  int m_dummy = 0;

  function automatic logic [7:0] flash_byte(logic [23:0] a);
    return 8'(a[7:0] * 13) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] exp_op(logic [2:0] v);
    return (v == 3'd0) ? 8'h03 : 8'h0B;
  endfunction

  function automatic int exp_dummy(logic [2:0] v);
    return (v == 3'd0) ? 0 : (v == 3'd1) ? 8 : 16;
  endfunction

  function automatic logic model_bit(int k);
    int j;
    logic [7:0] b;
    if (k < 32 + m_dummy) return k[0];
    j = k - 32 - m_dummy;
    b = flash_byte(m_cmd[23:0] + 24'(j / 8));
    return b[7 - (j % 8)];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flash device model
  initial begin
    logic pc, ps;
    pc = 1'b1; ps = 1'b0;
    forever begin
      @(cs_n or sclk);
      if (pc && !cs_n) begin
        m_rise = 0; m_cmd = '0; miso = 1'b0;
      end else if (!cs_n && !ps && sclk) begin
        if (m_rise < 32) m_cmd = {m_cmd[30:0], mosi};
        m_rise++;
      end else if (!cs_n && ps && !sclk) begin
        miso = model_bit(m_rise);
      end
      pc = cs_n; ps = sclk;
    end
  end

  // consumer
  initial forever begin
    @(negedge clk);
    out_ready = int'($urandom_range(99)) < ready_pct;
    if (out_valid && out_ready) begin
      if (rx_n < 512) rxbuf[rx_n] = out_data;
      rx_n++;
    end
  end

  task automatic run_load(input logic [2:0] v, input logic [23:0] a, input int cnt,
                          input int div, input int pct, input int abort_at,
                          input bit poke, input bit stall);
    int cyc, first_rise, csh, gap, hdiv, bad, first_bad;
    bit done_seen, ab_pend, ab_done, stall_done, ctl_bad;
    hdiv = (div == 0) ? 1 : div;
    rx_n = 0; ready_pct = pct; m_dummy = exp_dummy(v);
    @(negedge clk);
    variant = v; start_addr = a; byte_count = 16'(cnt); clk_div = 8'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R4", "select low after start", int'(cs_n), 0);
    chk(!err, "R3", "err cleared by accepted start", int'(err), 0);
    cyc = 0; first_rise = -1; csh = -1; gap = -1;
    done_seen = 0; ab_pend = 0; ab_done = 0; stall_done = 0; ctl_bad = 0;
    while (!done_seen && cyc < 60000) begin
      if (first_rise < 0 && sclk) first_rise = cyc;
      if (!hold_n || !wp_n || (cs_n && sclk)) ctl_bad = 1;
      if (poke && cyc == 40) begin
        start = 1'b1; start_addr = a ^ 24'h111111; byte_count = 16'd2; variant = 3'd2;
      end
      if (poke && cyc == 41) start = 1'b0;
      if (ab_pend) begin
        chk(cs_n && !sclk && !out_valid, "R9", "abort releases bus", int'({cs_n, sclk, out_valid}), 4);
        abort = 1'b0; ab_pend = 0; ab_done = 1;
      end else if (abort_at > 0 && !ab_done && rx_n >= abort_at) begin
        abort = 1'b1; ab_pend = 1;
      end
      if (stall && !stall_done && out_valid) begin
        int r0;
        logic [7:0] d0;
        repeat (4 * hdiv + 2) @(negedge clk);
        r0 = m_rise; d0 = out_data;
        repeat (100) @(negedge clk);
        chk(m_rise == r0 && !sclk, "R7", "clock stalled while byte pending", m_rise, r0);
        chk(out_valid && out_data == d0, "R7", "pending byte held", int'(out_data), int'(d0));
        ready_pct = 100; stall_done = 1;
      end
      if (cs_n && csh < 0) csh = cyc;
      if (done) begin
        done_seen = 1; gap = cyc - csh;
        chk(!busy, "R10", "busy low at done", int'(busy), 0);
      end
      @(negedge clk);
      cyc++;
    end
    chk(done_seen, "R10", "done pulse seen", int'(done_seen), 1);
    chk(!done, "R10", "done lasts one cycle", int'(done), 0);
    chk(gap >= 2 * hdiv, "R10", "select-high gap before done", gap, 2 * hdiv);
    chk(first_rise == hdiv, "R5", "first sclk rise delay", first_rise, hdiv);
    chk(!ctl_bad, "R1", "hold/wp high and sclk low when deselected", int'(ctl_bad), 0);
    chk(m_cmd[31:24] == exp_op(v), "R2", "opcode", int'(m_cmd[31:24]), int'(exp_op(v)));
    chk(m_cmd[23:0] == a, "R4", "address on mosi (R11 when poked)", int'(m_cmd[23:0]), int'(a));
    if (abort_at > 0)
      chk(rx_n >= abort_at, "R8", "bytes before abort", rx_n, abort_at);
    else
      chk(rx_n == cnt, "R8", "byte count", rx_n, cnt);
    bad = 0; first_bad = -1;
    for (int j = 0; j < rx_n && j < 512; j++)
      if (rxbuf[j] != flash_byte(a + 24'(j))) begin
        bad++;
        if (first_bad < 0) first_bad = j;
      end
    if (bad != 0)
      chk(0, "R6", "data byte", int'(rxbuf[first_bad]), int'(flash_byte(a + 24'(first_bad))));
    else
      chk(1, "R6", "data bytes", 0, 0);
  endtask

  task automatic reserved_try(input logic [2:0] v);
    @(negedge clk);
    variant = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && cs_n && err, "R3", "reserved code refused", int'({busy, cs_n, err}), 3);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !err && !out_valid, "R1", "reset state",
        int'({cs_n, sclk, busy, done, err, out_valid}), 32);
    chk(hold_n && wp_n, "R1", "hold/wp inactive", int'({hold_n, wp_n}), 3);

    run_load(3'd0, 24'h000100, 4, 1, 100, 0, 0, 0);
    run_load(3'd1, 24'hABCDEF, 5, 3, 100, 0, 0, 0);
    run_load(3'd2, 24'hFFFFFE, 4, 0, 70, 0, 0, 0);
    reserved_try(3'(3 + $urandom_range(4)));
    reserved_try(3'd7);
    run_load(3'd1, 24'h123456, 3, 2, 0, 0, 0, 1);
    run_load(3'd0, 24'h00ABC0, 6, 2, 100, 0, 1, 0);
    run_load(3'd2, 24'h400000, 0, 1, 80, 5, 0, 0);
    for (int i = 0; i < 8; i++)
      run_load(3'($urandom_range(2)), 24'($urandom), int'($urandom_range(12, 1)),
               int'($urandom_range(4)), int'($urandom_range(100, 30)), 0, 0, 0);
    finish_run();
  end
endmodule